// File: doc/BRIEF.md
# Sixteen-bit ALU with byte mode

This block is the arithmetic and logic stage of a small 16-bit register-machine processor. It is purely combinational. It receives a source operand, a destination operand, the current condition flags, a 4-bit operation select and a byte/word select. It returns the operation result, a write-enable that tells the register or memory stage whether to store that result, and the next values of the four condition flags.

Binary add, add with carry, subtract, subtract with carry and compare run through one shared binary adder. Decimal add with carry runs through a packed-BCD adder chain with one cell per nibble. Bitwise operations are computed in the top level. A shift unit handles the rotates, the byte swap and the sign extension.

In byte mode, only the low eight bits of each operand are used. The result comes back with its upper byte zero, and the sign, carry and overflow are taken at bit 7 instead of bit 15. The surrounding pipeline owns the flag register. It stores the returned flags every cycle, so an operation that leaves the flags alone returns the incoming flags unchanged.

Top module: `alu16_core`

## Requirements
- R1: The operation select encodes MOVE=0, ADD=1, ADDC=2, SUBC=3, SUB=4, CMP=5, DADD=6, BIT=7, BIC=8, BIS=9, XOR=10, AND=11, RRC=12, SWAP=13, RRA=14, SEXT=15. The write-enable is 0 for CMP and BIT and 1 for every other code. CMP and BIT still present the computed value on the result port and update the flags.
- R2: ADD returns dst+src and ADDC returns dst+src+C. C is the carry out of the active width. V is set when both operands have the same sign and the result has the other sign.
- R3: SUB and CMP compute dst+NOT(src)+1, and SUBC computes dst+NOT(src)+C. C is the carry out of that sum, which means "no borrow". V is set when the operand signs differ and the result sign differs from the sign of dst.
- R4: DADD adds dst, src and C as packed BCD. A nibble sum above 9 is corrected by adding 6 and passes a carry to the next nibble. The final decimal carry becomes C, and V is cleared.
- R5: AND and BIT compute src AND dst, and XOR computes src XOR dst. For all three, C = NOT Z. V is cleared, except that XOR sets V when both operands are negative.
- R6: MOVE returns src, BIC returns NOT(src) AND dst, BIS returns src OR dst, and SWAP exchanges the two bytes of dst. All four return the incoming flags unchanged. The flag vectors are ordered N,Z,C,V from bit 3 down to bit 0.
- R7: RRA shifts dst right one place, keeps the sign bit in place, moves the outgoing LSB into C and clears V.
- R8: RRC shifts dst right one place, puts the incoming C into the sign bit, moves the outgoing LSB into C and clears V.
- R9: SEXT copies bit 7 of dst into bits 15:8 and sets C = NOT Z with V cleared. SEXT and SWAP always act on the full word, whatever the byte select says.
- R10: When the byte select is 1, only bits 7:0 of the operands take part. A written result has bits 15:8 zero, and N, C and V are taken at bit 7.
- R11: Every operation that updates flags sets N from the sign bit of the active width and Z when the active-width result is zero. This holds for all 16 codes in both widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation select (R1 encoding) |
| byte_i | input | 1 | 1 = byte operation, 0 = word operation |
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| res_o | output | 16 | Operation result |
| wr_en_o | output | 1 | Result is to be stored |
| flags_o | output | 4 | Next flags {N,Z,C,V} |

## Verification
The bench builds the block with its default width of 16, which gives a byte width of 8 and a chain of four decimal cells. This places the carry, sign and overflow tap points at bits 7 and 15. It also makes the byte-mode decimal carry come from the second nibble cell. Directed cases put values at the signed boundaries (0x7FFF, 0x8000, 0x7F, 0x80) and into full decimal carry ripples. A sweep over every code in both widths then compares the outputs against a reference built from integer arithmetic.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_MOVE = 4'h0,
        OP_ADD  = 4'h1,
        OP_ADDC = 4'h2,
        OP_SUBC = 4'h3,
        OP_SUB  = 4'h4,
        OP_CMP  = 4'h5,
        OP_DADD = 4'h6,
        OP_BITT = 4'h7,
        OP_BICL = 4'h8,
        OP_BISE = 4'h9,
        OP_XORO = 4'hA,
        OP_ANDO = 4'hB,
        OP_RRC  = 4'hC,
        OP_SWAP = 4'hD,
        OP_RRA  = 4'hE,
        OP_SEXT = 4'hF
    } alu_op_e;

    // How the next flags are formed
    typedef enum logic [1:0] {
        FL_HOLD  = 2'd0,   // pass incoming flags
        FL_ARITH = 2'd1,   // N,Z from result, C and V from candidates
        FL_LOGIC = 2'd2,   // N,Z from result, C = not Z, V from candidate
        FL_NOV   = 2'd3    // N,Z from result, C from candidate, V cleared
    } flag_rule_e;

    // Shift unit selections, taken from the low two bits of the op code
    localparam logic [1:0] SH_RRC  = 2'd0;
    localparam logic [1:0] SH_SWAP = 2'd1;
    localparam logic [1:0] SH_RRA  = 2'd2;
    localparam logic [1:0] SH_SEXT = 2'd3;

endpackage

// File: rtl/alu16_adder.sv
module alu16_adder #(
    parameter int DATA_W = 16
) (
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              ovf_o
);
    localparam int HALF = DATA_W / 2;

    logic [HALF:0]   lo_sum;
    logic [DATA_W:0] full_sum;
    logic            a_s, b_s, r_s;

    assign lo_sum   = {1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]} + {{HALF{1'b0}}, cin};
    assign full_sum = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin};

    always_comb begin
        if (byte_mode) begin
            sum_o  = {{(DATA_W-HALF){1'b0}}, lo_sum[HALF-1:0]};
            cout_o = lo_sum[HALF];
            a_s    = a_i[HALF-1];
            b_s    = b_i[HALF-1];
            r_s    = lo_sum[HALF-1];
        end else begin
            sum_o  = full_sum[DATA_W-1:0];
            cout_o = full_sum[DATA_W];
            a_s    = a_i[DATA_W-1];
            b_s    = b_i[DATA_W-1];
            r_s    = full_sum[DATA_W-1];
        end
        ovf_o = (a_s == b_s) && (r_s != a_s);
    end

    // A carry out means the wrapped sum cannot exceed the first operand;
    // without one it cannot be below it.
    always_comb begin : p_carry_chk
        logic [DATA_W-1:0] a_act;
        a_act = byte_mode ? {{(DATA_W-HALF){1'b0}}, a_i[HALF-1:0]} : a_i;
        assert_carry_order_R2: assert (cout_o ? (sum_o <= a_act) : (sum_o >= a_act))
            else $error("carry out disagrees with sum ordering");
    end

endmodule

// File: rtl/alu16_bcd.sv
module alu16_bcd #(
    parameter int DATA_W = 16
) (
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o
);
    localparam int HALF      = DATA_W / 2;
    localparam int NIBS      = DATA_W / 4;
    localparam int HALF_NIBS = NIBS / 2;

    logic [NIBS:0]     cy;
    logic [DATA_W-1:0] raw;

    assign cy[0] = cin;

    for (genvar g = 0; g < NIBS; g++) begin : g_digit
        logic [4:0] t;
        assign t           = {1'b0, a_i[4*g +: 4]} + {1'b0, b_i[4*g +: 4]} + {4'b0000, cy[g]};
        assign cy[g+1]     = (t > 5'd9);
        assign raw[4*g +: 4] = cy[g+1] ? (t[3:0] + 4'd6) : t[3:0];
    end

    always_comb begin
        if (byte_mode) begin
            sum_o  = {{(DATA_W-HALF){1'b0}}, raw[HALF-1:0]};
            cout_o = cy[HALF_NIBS];
        end else begin
            sum_o  = raw;
            cout_o = cy[NIBS];
        end
    end

    // Valid decimal digits in must give valid decimal digits out
    always_comb begin : p_digit_chk
        logic ok_in;
        logic ok_out;
        ok_in  = 1'b1;
        ok_out = 1'b1;
        for (int k = 0; k < NIBS; k++) begin
            if (a_i[4*k +: 4] > 4'd9 || b_i[4*k +: 4] > 4'd9) ok_in = 1'b0;
            if (sum_o[4*k +: 4] > 4'd9) ok_out = 1'b0;
        end
        assert_digit_range_R4: assert (!ok_in || ok_out)
            else $error("decimal add produced a non-decimal digit");
    end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
    import alu16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [1:0]        sel_i,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] d_i,
    input  logic              cin,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);
    localparam int HALF = DATA_W / 2;

    always_comb begin
        res_o  = '0;
        cout_o = cin;
        unique case (sel_i)
            SH_RRC: begin
                cout_o = d_i[0];
                if (byte_mode) res_o[HALF-1:0] = {cin, d_i[HALF-1:1]};
                else           res_o           = {cin, d_i[DATA_W-1:1]};
            end
            SH_RRA: begin
                cout_o = d_i[0];
                if (byte_mode) res_o[HALF-1:0] = {d_i[HALF-1], d_i[HALF-1:1]};
                else           res_o           = {d_i[DATA_W-1], d_i[DATA_W-1:1]};
            end
            SH_SWAP: res_o = {d_i[HALF-1:0], d_i[DATA_W-1:HALF]};
            SH_SEXT: res_o = {{(DATA_W-HALF){d_i[HALF-1]}}, d_i[HALF-1:0]};
            default: res_o = '0;
        endcase
    end

    // Rotates neither create nor lose set bits: what enters at the top
    // matches what leaves through the carry.
    always_comb begin : p_bits_chk
        logic [DATA_W-1:0] d_act;
        logic              top_in;
        d_act  = byte_mode ? {{(DATA_W-HALF){1'b0}}, d_i[HALF-1:0]} : d_i;
        top_in = (sel_i == SH_RRC) ? cin : (byte_mode ? d_i[HALF-1] : d_i[DATA_W-1]);
        if (sel_i == SH_RRC || sel_i == SH_RRA) begin
            assert_rotate_bits_R8: assert ($countones(res_o) + int'(cout_o)
                                           == $countones(d_act) + int'(top_in))
                else $error("rotate lost or gained a bit");
        end
    end

endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
    import alu16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  flag_rule_e        rule_i,
    input  logic              narrow_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              c_cand_i,
    input  logic              v_cand_i,
    input  logic [3:0]        flags_i,
    output logic [3:0]        flags_o
);
    localparam int HALF = DATA_W / 2;

    logic n_now, z_now;

    assign n_now = narrow_i ? res_i[HALF-1] : res_i[DATA_W-1];
    assign z_now = narrow_i ? (res_i[HALF-1:0] == '0) : (res_i == '0);

    always_comb begin
        unique case (rule_i)
            FL_HOLD:  flags_o = flags_i;
            FL_ARITH: flags_o = {n_now, z_now, c_cand_i, v_cand_i};
            FL_LOGIC: flags_o = {n_now, z_now, ~z_now, v_cand_i};
            FL_NOV:   flags_o = {n_now, z_now, c_cand_i, 1'b0};
            default:  flags_o = flags_i;
        endcase
    end

    // A zero result is never negative
    always_comb begin
        if (rule_i != FL_HOLD) begin
            assert_zero_not_neg_R11: assert (!(flags_o[2] && flags_o[3]))
                else $error("Z and N both set");
        end
    end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [3:0]        op_i,
    input  logic              byte_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [3:0]        flags_i,
    output logic [DATA_W-1:0] res_o,
    output logic              wr_en_o,
    output logic [3:0]        flags_o
);
    localparam int HALF = DATA_W / 2;

    alu_op_e           op;
    logic              narrow;
    logic [DATA_W-1:0] src_m, dst_m;
    logic              c_in;

    // adder side
    logic [DATA_W-1:0] add_b, add_sum;
    logic              add_cin, add_c, add_v;
    // decimal side
    logic [DATA_W-1:0] bcd_sum;
    logic              bcd_c;
    // shift side
    logic [DATA_W-1:0] sh_res;
    logic              sh_c;
    // selection
    flag_rule_e        rule;
    logic              c_cand, v_cand;
    logic              xor_v;

    assign op     = alu_op_e'(op_i);
    assign c_in   = flags_i[1];
    assign narrow = byte_i && (op != OP_SWAP) && (op != OP_SEXT);
    assign src_m  = narrow ? {{(DATA_W-HALF){1'b0}}, src_i[HALF-1:0]} : src_i;
    assign dst_m  = narrow ? {{(DATA_W-HALF){1'b0}}, dst_i[HALF-1:0]} : dst_i;
    assign xor_v  = narrow ? (src_m[HALF-1] & dst_m[HALF-1]) : (src_m[DATA_W-1] & dst_m[DATA_W-1]);

    always_comb begin
        add_b   = src_m;
        add_cin = 1'b0;
        unique case (op)
            OP_ADDC:         add_cin = c_in;
            OP_SUBC:         begin add_b = ~src_m; add_cin = c_in; end
            OP_SUB, OP_CMP:  begin add_b = ~src_m; add_cin = 1'b1; end
            default:         add_cin = 1'b0;
        endcase
    end

    alu16_adder #(.DATA_W(DATA_W)) u_add (
        .byte_mode (narrow),
        .a_i       (dst_m),
        .b_i       (add_b),
        .cin       (add_cin),
        .sum_o     (add_sum),
        .cout_o    (add_c),
        .ovf_o     (add_v)
    );

    alu16_bcd #(.DATA_W(DATA_W)) u_bcd (
        .byte_mode (narrow),
        .a_i       (dst_m),
        .b_i       (src_m),
        .cin       (c_in),
        .sum_o     (bcd_sum),
        .cout_o    (bcd_c)
    );

    alu16_shift #(.DATA_W(DATA_W)) u_shf (
        .sel_i     (op_i[1:0]),
        .byte_mode (narrow),
        .d_i       (dst_m),
        .cin       (c_in),
        .res_o     (sh_res),
        .cout_o    (sh_c)
    );

    always_comb begin
        res_o   = src_m;
        wr_en_o = 1'b1;
        rule    = FL_HOLD;
        c_cand  = c_in;
        v_cand  = 1'b0;
        unique case (op)
            OP_MOVE: res_o = src_m;
            OP_ADD, OP_ADDC, OP_SUBC, OP_SUB: begin
                res_o  = add_sum;
                rule   = FL_ARITH;
                c_cand = add_c;
                v_cand = add_v;
            end
            OP_CMP: begin
                res_o   = add_sum;
                rule    = FL_ARITH;
                c_cand  = add_c;
                v_cand  = add_v;
                wr_en_o = 1'b0;
            end
            OP_DADD: begin
                res_o  = bcd_sum;
                rule   = FL_NOV;
                c_cand = bcd_c;
            end
            OP_BITT: begin
                res_o   = src_m & dst_m;
                rule    = FL_LOGIC;
                wr_en_o = 1'b0;
            end
            OP_BICL: res_o = ~src_m & dst_m;
            OP_BISE: res_o = src_m | dst_m;
            OP_XORO: begin
                res_o  = src_m ^ dst_m;
                rule   = FL_LOGIC;
                v_cand = xor_v;
            end
            OP_ANDO: begin
                res_o = src_m & dst_m;
                rule  = FL_LOGIC;
            end
            OP_RRC, OP_RRA: begin
                res_o  = sh_res;
                rule   = FL_NOV;
                c_cand = sh_c;
            end
            OP_SWAP: res_o = sh_res;
            OP_SEXT: begin
                res_o = sh_res;
                rule  = FL_LOGIC;
            end
            default: res_o = src_m;
        endcase
    end

    alu16_flags #(.DATA_W(DATA_W)) u_flg (
        .rule_i   (rule),
        .narrow_i (narrow),
        .res_i    (res_o),
        .c_cand_i (c_cand),
        .v_cand_i (v_cand),
        .flags_i  (flags_i),
        .flags_o  (flags_o)
    );

    // Stored byte results never carry anything in the upper byte
    always_comb begin
        if (narrow && wr_en_o) begin
            assert_byte_upper_R10: assert (res_o[DATA_W-1:HALF] == '0)
                else $error("byte result has upper bits set");
        end
    end

endmodule

// File: tb/sim_alu16_core.sv
`timescale 1ns/1ps
module sim_alu16_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic        byte_i = 1'b0;
    logic [15:0] src_i = '0;
    logic [15:0] dst_i = '0;
    logic [3:0]  flags_i = '0;
    logic [15:0] res_o;
    logic        wr_en_o;
    logic [3:0]  flags_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    alu16_core u0 (
        .op_i(op_i), .byte_i(byte_i), .src_i(src_i), .dst_i(dst_i),
        .flags_i(flags_i), .res_o(res_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
    );

    // Reference built from integer arithmetic on the requirement text
    function automatic logic [20:0] model(input logic [3:0] op, input logic bm,
                                          input logic [15:0] s, input logic [15:0] d,
                                          input logic [3:0] f);
        int w, mask, sgn, sv, dv, r, ss, ds, t, ad, sd, lim;
        logic n, z, c, v, we, hold, ci;
        w    = (bm && op != 4'd13 && op != 4'd15) ? 8 : 16;
        mask = (1 << w) - 1;
        sgn  = 1 << (w - 1);
        sv = int'(s) & mask;
        dv = int'(d) & mask;
        ss = (sv >= sgn) ? sv - 2*sgn : sv;
        ds = (dv >= sgn) ? dv - 2*sgn : dv;
        ci = f[1];
        we = 1'b1; hold = 1'b0; c = ci; v = 1'b0; r = 0;
        case (op)
            4'd0: begin r = sv; hold = 1'b1; end
            4'd1, 4'd2: begin
                t = (op == 4'd2 && ci) ? 1 : 0;
                r = dv + sv + t;
                c = (r > mask);
                v = (ds + ss + t >= sgn) || (ds + ss + t < -sgn);
            end
            4'd3, 4'd4, 4'd5: begin
                t = (op == 4'd3) ? (ci ? 1 : 0) : 1;
                r = dv + ((~sv) & mask) + t;
                c = (r > mask);
                v = (ds - ss - 1 + t >= sgn) || (ds - ss - 1 + t < -sgn);
                if (op == 4'd5) we = 1'b0;
            end
            4'd6: begin
                ad = 0; sd = 0;
                for (int i = w/4 - 1; i >= 0; i--) begin
                    ad = ad*10 + ((dv >> (4*i)) & 15);
                    sd = sd*10 + ((sv >> (4*i)) & 15);
                end
                lim = (w == 8) ? 100 : 10000;
                t = ad + sd + (ci ? 1 : 0);
                c = (t >= lim);
                t = t % lim;
                for (int i = 0; i < w/4; i++) begin
                    r = r | ((t % 10) << (4*i));
                    t = t / 10;
                end
            end
            4'd7:  begin r = sv & dv; c = (r != 0); we = 1'b0; end
            4'd8:  begin r = (~sv) & dv; hold = 1'b1; end
            4'd9:  begin r = sv | dv; hold = 1'b1; end
            4'd10: begin r = sv ^ dv; c = (r != 0); v = ((sv & sgn) != 0) && ((dv & sgn) != 0); end
            4'd11: begin r = sv & dv; c = (r != 0); end
            4'd12: begin r = (dv >> 1) | (ci ? sgn : 0); c = dv[0]; end
            4'd13: begin r = ((int'(d) & 255) << 8) | (int'(d) >> 8); hold = 1'b1; end
            4'd14: begin r = (dv >> 1) | (dv & sgn); c = dv[0]; end
            default: begin
                r = int'(d) & 255;
                if (d[7]) r = r | 32'hFF00;
                c = (r != 0);
            end
        endcase
        r = r & mask;
        n = (r & sgn) != 0;
        z = (r == 0);
        if (hold) {n, z, c, v} = f;
        return {we, n, z, c, v, r[15:0]};
    endfunction

    task automatic apply(input logic [3:0] op, input logic bm, input logic [15:0] s,
                         input logic [15:0] d, input logic [3:0] f);
        @(negedge clk);
        op_i = op; byte_i = bm; src_i = s; dst_i = d; flags_i = f;
        #1;
    endtask

    task automatic compare(input string tag, input logic [20:0] exp_v);
        logic [20:0] act;
        act = {wr_en_o, flags_o, res_o};
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s op=%0h byte=%0b src=%h dst=%h fl=%b: got we=%b nzcv=%b res=%h, expected we=%b nzcv=%b res=%h",
                     tag, op_i, byte_i, src_i, dst_i, flags_i,
                     act[20], act[19:16], act[15:0], exp_v[20], exp_v[19:16], exp_v[15:0]);
        end
    endtask

    // Directed check with hand-worked expected values
    task automatic lit(input string tag, input logic [3:0] op, input logic bm,
                       input logic [15:0] s, input logic [15:0] d, input logic [3:0] f,
                       input logic we, input logic [3:0] nzcv, input logic [15:0] r);
        apply(op, bm, s, d, f);
        compare(tag, {we, nzcv, r});
    endtask

    task automatic t_reset();
        // inputs held at zero (MOVE, flags 0) during reset
        #1;
        compare("R6 reset state", {1'b1, 4'b0000, 16'h0000});
    endtask

    task automatic t_add();
        lit("R2 signed overflow", 4'd1, 0, 16'h0001, 16'h7FFF, 4'b0000, 1, 4'b1001, 16'h8000);
        lit("R2 carry to zero",   4'd1, 0, 16'h0001, 16'hFFFF, 4'b0000, 1, 4'b0110, 16'h0000);
        lit("R2 add with carry",  4'd2, 0, 16'h0010, 16'h0020, 4'b0010, 1, 4'b0000, 16'h0031);
    endtask

    task automatic t_sub();
        lit("R3 equal",         4'd4, 0, 16'h0005, 16'h0005, 4'b0000, 1, 4'b0110, 16'h0000);
        lit("R3 borrow",        4'd4, 0, 16'h0005, 16'h0003, 4'b0000, 1, 4'b1000, 16'hFFFE);
        lit("R3 subc no carry", 4'd3, 0, 16'h0001, 16'h0003, 4'b0000, 1, 4'b0010, 16'h0001);
        lit("R3 overflow",      4'd4, 0, 16'h0001, 16'h8000, 4'b0000, 1, 4'b0011, 16'h7FFF);
    endtask

    task automatic t_nowrite();
        lit("R1 compare no write", 4'd5, 0, 16'h0005, 16'h0005, 4'b0000, 0, 4'b0110, 16'h0000);
        lit("R1 bit test no write", 4'd7, 0, 16'h00F0, 16'h0F30, 4'b0000, 0, 4'b0010, 16'h0030);
    endtask

    task automatic t_dadd();
        lit("R4 ripple",      4'd6, 0, 16'h0001, 16'h0999, 4'b0000, 1, 4'b0000, 16'h1000);
        lit("R4 full carry",  4'd6, 0, 16'h0001, 16'h9999, 4'b0000, 1, 4'b0110, 16'h0000);
        lit("R4 carry in",    4'd6, 0, 16'h0025, 16'h0048, 4'b0010, 1, 4'b0000, 16'h0074);
        lit("R4 byte carry",  4'd6, 1, 16'h0001, 16'h1299, 4'b0000, 1, 4'b0110, 16'h0000);
    endtask

    task automatic t_logic();
        lit("R5 and nonzero", 4'd11, 0, 16'hFF00, 16'h8F0F, 4'b0001, 1, 4'b1010, 16'h8F00);
        lit("R5 and zero",    4'd11, 0, 16'h00FF, 16'hFF00, 4'b0011, 1, 4'b0100, 16'h0000);
        lit("R5 xor both neg", 4'd10, 0, 16'h8001, 16'h8003, 4'b0000, 1, 4'b0011, 16'h0002);
        lit("R5 xor zero",    4'd10, 0, 16'h1234, 16'h1234, 4'b0000, 1, 4'b0100, 16'h0000);
    endtask

    task automatic t_hold();
        lit("R6 move",  4'd0,  0, 16'hA5A5, 16'h0000, 4'b1011, 1, 4'b1011, 16'hA5A5);
        lit("R6 clear bits", 4'd8, 0, 16'h00FF, 16'h1234, 4'b0101, 1, 4'b0101, 16'h1200);
        lit("R6 set bits",   4'd9, 0, 16'h0F00, 16'h1234, 4'b0000, 1, 4'b0000, 16'h1F34);
        lit("R6 swap",  4'd13, 0, 16'h0000, 16'h12AB, 4'b1111, 1, 4'b1111, 16'hAB12);
    endtask

    task automatic t_rra();
        lit("R7 word",    4'd14, 0, 16'h0000, 16'h8003, 4'b0000, 1, 4'b1010, 16'hC001);
        lit("R7 byte",    4'd14, 1, 16'h0000, 16'h1281, 4'b0001, 1, 4'b1010, 16'h00C0);
        lit("R7 to zero", 4'd14, 0, 16'h0000, 16'h0001, 4'b0000, 1, 4'b0110, 16'h0000);
    endtask

    task automatic t_rrc();
        lit("R8 carry in",  4'd12, 0, 16'h0000, 16'h0002, 4'b0010, 1, 4'b1000, 16'h8001);
        lit("R8 carry out", 4'd12, 0, 16'h0000, 16'h0001, 4'b0000, 1, 4'b0110, 16'h0000);
        lit("R8 byte",      4'd12, 1, 16'h0000, 16'hFF00, 4'b0010, 1, 4'b1000, 16'h0080);
    endtask

    task automatic t_sext();
        lit("R9 negative",      4'd15, 0, 16'h0000, 16'h1280, 4'b0000, 1, 4'b1010, 16'hFF80);
        lit("R9 byte ignored",  4'd15, 1, 16'h0000, 16'hAB7F, 4'b0000, 1, 4'b0010, 16'h007F);
        lit("R9 zero",          4'd15, 0, 16'h0000, 16'h5500, 4'b0011, 1, 4'b0100, 16'h0000);
        lit("R9 swap byte ignored", 4'd13, 1, 16'h0000, 16'h12AB, 4'b0000, 1, 4'b0000, 16'hAB12);
    endtask

    task automatic t_byte();
        lit("R10 add carry",    4'd1, 1, 16'h1201, 16'h34FF, 4'b0000, 1, 4'b0110, 16'h0000);
        lit("R10 add overflow", 4'd1, 1, 16'h0001, 16'hFF7F, 4'b0000, 1, 4'b1001, 16'h0080);
        lit("R10 move clears",  4'd0, 1, 16'hABCD, 16'h0000, 4'b0000, 1, 4'b0000, 16'h00CD);
        lit("R10 sub borrow",   4'd4, 1, 16'h0001, 16'hAA00, 4'b0000, 1, 4'b1000, 16'h00FF);
    endtask

    task automatic t_sweep();
        for (int it = 0; it < 300; it++) begin
            for (int o = 0; o < 16; o++) begin
                for (int b = 0; b < 2; b++) begin
                    logic [15:0] s, d;
                    logic [3:0]  f;
                    s = 16'($urandom);
                    d = 16'($urandom);
                    f = 4'($urandom);
                    if (o == 6) begin
                        for (int k = 0; k < 4; k++) begin
                            s[4*k +: 4] = 4'($urandom % 10);
                            d[4*k +: 4] = 4'($urandom % 10);
                        end
                    end
                    apply(4'(o), b[0], s, d, f);
                    compare("R11 sweep", model(4'(o), b[0], s, d, f));
                end
            end
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired before the run completed");
        summary();
    end

    initial begin
        repeat (4) @(posedge clk);
        t_reset();
        rst_n = 1'b1;
        t_add();
        t_sub();
        t_nowrite();
        t_dadd();
        t_logic();
        t_hold();
        t_rra();
        t_rrc();
        t_sext();
        t_byte();
        t_sweep();
        summary();
    end

endmodule